// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block merges the interrupt pins of the devices on a host PCI bus onto the sixteen request inputs of a legacy interrupt controller. There are two stages. The first stage swizzles each device pin onto one of four shared interrupt lines (A..D). It does this by rotating the pin number by the slot number, so that devices in neighbouring slots spread their INTA pins across different shared lines. The second stage sends each shared line to the controller input named by its own programmable routing byte. A routing byte of 16 or more switches the line off.

Each controller input is the OR of every shared line routed to it, so several lines can share one input. The four routing bytes are written and read through a small byte-wide port. A write takes effect on the next clock, and a read returns the stored byte exactly as written.

The request vector is indexed by slot and pin: bit `slot*4 + pin`, where pin 0..3 stands for INTA..INTD. The controller outputs are recomputed combinationally from the request levels and the routing bytes. They are registered once before they leave the block.

Top module: `pci_irq_router`

## Requirements
- R1: During reset and on the first cycle after it, `irq_out` is zero. After reset the routing bytes read back as the selected profile. Profile 0 gives line A = 0x80 and lines B..D = 0x00. Profile 1 gives A = B = 0x0A and C = D = 0x0B.
- R2: Request bit `slot*4 + pin` drives shared line `(pin + slot - 1) mod 4`. Line 0 is A and line 3 is D. For example, slot 0 INTA lands on D and slot 1 INTA lands on A.
- R3: A shared line whose routing byte holds a value below 16 drives controller input number equal to that value.
- R4: A shared line whose routing byte is 16 or more has no effect on `irq_out`. This covers bit 7 set, and also bits 6..4 nonzero.
- R5: A shared line is the OR of every device request that rotates onto it. A controller input is the OR of every shared line routed to it.
- R6: When `cfg_we` is high at a rising clock edge, `cfg_wdata` is stored in the routing byte selected by `cfg_addr` (0 = line A .. 3 = line D). It is visible on `cfg_rdata` after that edge, with all 8 bits unchanged.
- R7: A change on `dev_req` appears on `irq_out` after exactly one rising clock edge.
- R8: When `cfg_we` is low, no routing byte changes, whatever `cfg_addr` and `cfg_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | SLOTS*4 | Device interrupt levels, bit slot*4+pin |
| cfg_we | input | 1 | Routing byte write enable |
| cfg_addr | input | 2 | Routing byte select, 0 = line A .. 3 = line D |
| cfg_wdata | input | 8 | Routing byte write data |
| cfg_rdata | output | 8 | Routing byte selected by cfg_addr |
| irq_out | output | IRQS | Registered controller request levels |

## Verification
A corrupted routing byte makes a shared line appear on the wrong controller input, or on no input, one clock after the next request. It also shows up directly on `cfg_rdata` in the cycle after the write. A wrong rotation term moves a single device's request to a neighbouring input, which the one-device-at-a-time vectors separate. A lost OR term shows only when two sources share a path, so the bench holds two devices on one line and drops them one at a time.

// File: rtl/pci_irq_router.sv
`timescale 1ns/1ps
module pci_irq_router #(
  parameter int SLOTS   = 8,
  parameter int IRQS    = 16,
  parameter int PROFILE = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SLOTS*4-1:0]   dev_req,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  output logic [IRQS-1:0]      irq_out
);

  localparam logic [3:0][7:0] ROUTE_RST = (PROFILE == 1) ?
    {8'h0b, 8'h0b, 8'h0a, 8'h0a} : {8'h00, 8'h00, 8'h00, 8'h80};

  logic [3:0][7:0]   route_q;
  logic [3:0]        shared;
  logic [IRQS-1:0]   irq_next;

  always_ff @(posedge clk) begin
    if (!rst_n)      route_q <= ROUTE_RST;
    else if (cfg_we) route_q[cfg_addr] <= cfg_wdata;
  end

  assign cfg_rdata = route_q[cfg_addr];

  always_comb begin
    shared = '0;
    for (int s = 0; s < SLOTS; s++)
      for (int p = 0; p < 4; p++)
        shared[(p + s + 3) % 4] = shared[(p + s + 3) % 4] | dev_req[s*4 + p];
  end

  always_comb begin
    irq_next = '0;
    for (int k = 0; k < IRQS; k++)
      for (int l = 0; l < 4; l++)
        if (32'(route_q[l]) == k) irq_next[k] = irq_next[k] | shared[l];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= irq_next;
  end

  // R1
  out_clear_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> irq_out == '0);

  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> route_q[$past(cfg_addr)] == $past(cfg_wdata));

  // R8
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(route_q));

  // R4
  all_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q[0][7:4] != 0 && route_q[1][7:4] != 0 &&
     route_q[2][7:4] != 0 && route_q[3][7:4] != 0 && !cfg_we) |=> irq_out == '0);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req == '0 |=> irq_out == '0);

endmodule

// File: tb/test_pci_irq_router.sv
`timescale 1ns/1ps
module test_pci_irq_router;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] dev_req = '0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata, rdata_p1;
  logic [15:0] irq_out, irq_p1;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pci_irq_router i_pci_irq_router (.clk(clk), .rst_n(rst_n), .dev_req(dev_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_out(irq_out));

  pci_irq_router #(.PROFILE(1)) i_pci_irq_router_p1 (.clk(clk), .rst_n(rst_n),
    .dev_req(dev_req), .cfg_we(1'b0), .cfg_addr(cfg_addr), .cfg_wdata(8'h00),
    .cfg_rdata(rdata_p1), .irq_out(irq_p1));

  // {routes D,C,B,A ; dev_req ; expected irq_out}
  localparam logic [79:0] VEC [8] = '{
    {32'h06050403, 32'h00000010, 16'h0008},  // R2 R3 slot1 INTA -> A
    {32'h06050403, 32'h00000001, 16'h0040},  // R2 slot0 INTA -> D
    {32'h06050403, 32'h00000200, 16'h0020},  // R2 slot2 INTB -> C
    {32'h06050403, 32'h80000000, 16'h0010},  // R2 slot7 INTD -> B
    {32'h0b0b0a0a, 32'h00001020, 16'h0c00},  // R3 two lines two inputs
    {32'h00100f80, 32'hffffffff, 16'h8001},  // R4 0x80 and 0x10 route nowhere
    {32'h07070707, 32'h00040000, 16'h0080},  // R5 all lines merged
    {32'h07070707, 32'h00000000, 16'h0000}   // R5 idle
  };

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq during reset", irq_out, 16'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq after reset", irq_out, 16'h0);
    for (int a = 0; a < 4; a++) begin
      cfg_addr = 2'(a);
      #1;
      check("R1 profile0 route", {8'h0, cfg_rdata}, (a == 0) ? 16'h80 : 16'h00);
      check("R1 profile1 route", {8'h0, rdata_p1}, (a < 2) ? 16'h0a : 16'h0b);
    end

    for (int v = 0; v < 8; v++) begin
      for (int l = 0; l < 4; l++) wr(2'(l), VEC[v][48 + l*8 +: 8]);
      dev_req = VEC[v][47:16];
      @(negedge clk);
      check($sformatf("R2 R3 R4 R5 vector %0d", v), irq_out, VEC[v][15:0]);
    end

    // R6 write visible after the edge, full byte kept
    dev_req = '0;
    cfg_addr = 2'd2; cfg_wdata = 8'ha5; cfg_we = 1;
    #1;
    check("R6 old value before edge", {8'h0, cfg_rdata}, 16'h07);
    @(negedge clk);
    cfg_we = 0;
    check("R6 readback", {8'h0, cfg_rdata}, 16'ha5);

    // R8 write enable low ignored
    cfg_addr = 2'd2; cfg_wdata = 8'h3c;
    repeat (2) @(negedge clk);
    check("R8 no write", {8'h0, cfg_rdata}, 16'ha5);

    // R7 one-edge latency
    wr(2'd0, 8'd3);
    dev_req = 32'h10;
    #1;
    check("R7 before edge", irq_out, 16'h0);
    @(negedge clk);
    check("R7 after one edge", irq_out, 16'h0008);

    // R5 two devices on line A: slot1 INTA and slot2 INTD
    dev_req = 32'h00000810;
    @(negedge clk);
    check("R5 both high", irq_out, 16'h0008);
    dev_req = 32'h00000800;
    @(negedge clk);
    check("R5 one dropped", irq_out, 16'h0008);
    dev_req = 32'h0;
    @(negedge clk);
    check("R5 both dropped", irq_out, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule